// File: doc/BRIEF.md
# BCD Clock Calendar with Two Alarms

This block keeps wall-clock time and date as packed BCD bytes: seconds, minutes, hours, weekday, day of month, month and a two-digit year standing for 2000 to 2099. A free-running enable `tick_i` is divided by a parameterised prescaler into one-second steps. The hour byte is held in either 24-hour form or 12-hour form with an AM/PM bit. Software reads and writes every byte through a simple register port with single-cycle write strobes and combinational read data.

Two identical alarm units compare seconds, minutes, hours and weekday against the running time. Each alarm byte has its own "don't care" bit. A match sets a sticky flag. The flag drives active-low interrupt outputs, gated by per-alarm enables and a routing bit. A flag is cleared by touching that alarm's registers or by writing the status byte. A control bit freezes the clock.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, reads return seconds, minutes, hours and year as 0x00; weekday, day and month as 0x01; all alarm bytes, control (0x0F) and status (0x10) as 0x00; both interrupt outputs are high.
- R2: Time bytes sit at 0x00..0x06 as seconds, minutes, hours, weekday, day, month, year. Alarm 0 sits at 0x07..0x0A and alarm 1 at 0x0B..0x0E, each as seconds, minutes, hours, weekday. Stored widths are 7,7,7,3,6,5,8 bits for the time bytes, 8 bits for alarm bytes, and bits {7,2,1,0} for control. Unstored bits and unmapped addresses read 0.
- R3: In 24-hour mode (hour bit 6 = 0), seconds and minutes wrap 0x59 to 0x00 and carry. The hour wraps 0x23 to 0x00 and advances the date.
- R4: In 12-hour mode (hour bit 6 = 1, bit 5 = PM, bits 4:0 a BCD hour 01..12), 11 goes to 12 and toggles PM, while 12 goes to 01 and keeps PM. Only 11 PM to 12 AM advances the date, and bit 6 is kept.
- R5: The day wraps to 0x01 after the month's last day: 31, 30 for months 4, 6, 9 and 11, and for February 29 when the year value is divisible by 4, else 28. The month wraps 0x12 to 0x01 and increments the year, and the year wraps 0x99 to 0x00.
- R6: The weekday advances with the date and wraps 0x07 to 0x01.
- R7: The time advances one second per DIV cycles with `tick_i` high. Any time-byte write restarts this count, so the next step comes DIV ticks after the write.
- R8: With control bit 7 set, the time does not advance.
- R9: An alarm matches on a time step when every field either has bit 7 set or has bits 6:0 equal to the new time's bits 6:0. A match sets status bit 0 (alarm 0) or bit 1 (alarm 1).
- R10: Control bits 0 and 1 enable alarms 0 and 1. With control bit 2 clear, `irq_main_no` is low while any enabled alarm's flag is set. With it set, alarm 1 drives `irq_aux_no` instead. Both outputs are active low, and `irq_aux_no` stays high while control bit 2 is clear.
- R11: A read (`rd_en_i`) or write of any byte of an alarm clears that alarm's flag only.
- R12: A write to status clears every flag whose written bit is 0 and leaves flags whose bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaler enable, DIV of these make one second |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (for read side effects) |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| irq_main_no | output | 1 | Primary interrupt, active low |
| irq_aux_no | output | 1 | Second interrupt for alarm 1 when routed, active low |

## Verification
The bench sweeps every hour of the day in both hour formats from hh:59:59, catching a design that advances the date at noon, skips 12, or toggles AM/PM on the wrong step. It sweeps every month's last and second-to-last day in a common year, two leap years and year 99. A wrong month-length table or leap rule would wrap a day early or late, and a broken year carry would stop at 99. It hits the prescaler restart by writing after DIV-1 ticks, which a free-running divider would step one tick early. It also covers field masking, routing, and both flag-clearing paths, where a design would raise the wrong output or clear the other alarm's flag.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int unsigned NUM_TIME   = 7;
  localparam int unsigned NUM_FIELDS = 4;
  localparam int unsigned NUM_ALM    = 2;
  localparam int unsigned ALM_BASE   = 7;
  localparam int unsigned CTRL_ADDR  = 15;
  localparam int unsigned STAT_ADDR  = 16;

  localparam int unsigned F_SEC  = 0;
  localparam int unsigned F_MIN  = 1;
  localparam int unsigned F_HOUR = 2;
  localparam int unsigned F_WDAY = 3;
  localparam int unsigned F_MDAY = 4;
  localparam int unsigned F_MON  = 5;
  localparam int unsigned F_YEAR = 6;

  localparam logic [7:0] CTRL_MASK = 8'h87;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] bcd_bin(input logic [7:0] v);
    return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] m;
    logic [7:0] y;
    m = bcd_bin(mon);
    y = bcd_bin(yr);
    case (m)
      8'd2:                    return (y[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'h30;
      default:                 return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] time_mask(input logic [2:0] idx);
    case (idx)
      3'd0, 3'd1, 3'd2: return 8'h7f;
      3'd3:             return 8'h07;
      3'd4:             return 8'h3f;
      3'd5:             return 8'h1f;
      default:          return 8'hff;
    endcase
  endfunction
endpackage

// File: rtl/bcd_rtc_prescaler.sv
module bcd_rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic restart_i,
  output logic step_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign step_o = tick_i & run_i & ~restart_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (restart_i)        cnt_q <= '0;
    else if (tick_i && run_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  a_r7_restart_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));
  a_r8_halt_holds_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/bcd_rtc_timekeeper.sv
module bcd_rtc_timekeeper
  import bcd_rtc_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [2:0]                 idx_i,
  input  logic [7:0]                 wdata_i,
  input  logic                       step_i,
  output logic [NUM_TIME-1:0][7:0]   time_o
);
  localparam logic [NUM_TIME-1:0][7:0] RESET_TIME =
    {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  logic [NUM_TIME-1:0][7:0] time_q, time_n;
  logic       sec_wrap, min_wrap, day_carry, mday_wrap, mon_wrap;
  logic       pm;
  logic [4:0] h12;
  logic [7:0] h12_inc, hour_adv;

  always_comb begin
    sec_wrap  = time_q[F_SEC] == 8'h59;
    min_wrap  = time_q[F_MIN] == 8'h59;
    mday_wrap = time_q[F_MDAY] == month_last_day(time_q[F_MON], time_q[F_YEAR]);
    mon_wrap  = time_q[F_MON] == 8'h12;
    pm        = time_q[F_HOUR][5];
    h12       = time_q[F_HOUR][4:0];
    h12_inc   = bcd_inc({3'b000, h12});
    day_carry = 1'b0;
    if (time_q[F_HOUR][6]) begin
      // 12h: 11 flips the meridiem, only 11 PM rolls the date
      if (h12 == 5'h12) begin
        h12 = 5'h01;
      end else if (h12 == 5'h11) begin
        h12       = 5'h12;
        day_carry = pm;
        pm        = ~pm;
      end else begin
        h12 = h12_inc[4:0];
      end
      hour_adv = {2'b01, pm, h12};
    end else if (time_q[F_HOUR] == 8'h23) begin
      hour_adv  = 8'h00;
      day_carry = 1'b1;
    end else begin
      hour_adv = bcd_inc(time_q[F_HOUR]);
    end
  end

  always_comb begin
    time_n = time_q;
    if (step_i) begin
      time_n[F_SEC] = sec_wrap ? 8'h00 : bcd_inc(time_q[F_SEC]);
      if (sec_wrap) begin
        time_n[F_MIN] = min_wrap ? 8'h00 : bcd_inc(time_q[F_MIN]);
        if (min_wrap) begin
          time_n[F_HOUR] = hour_adv;
          if (day_carry) begin
            time_n[F_WDAY] = (time_q[F_WDAY] == 8'h07) ? 8'h01 : bcd_inc(time_q[F_WDAY]);
            time_n[F_MDAY] = mday_wrap ? 8'h01 : bcd_inc(time_q[F_MDAY]);
            if (mday_wrap) begin
              time_n[F_MON] = mon_wrap ? 8'h01 : bcd_inc(time_q[F_MON]);
              if (mon_wrap)
                time_n[F_YEAR] = (time_q[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(time_q[F_YEAR]);
            end
          end
        end
      end
    end
    if (wr_i && idx_i != 3'd7)
      time_n[idx_i] = wdata_i & time_mask(idx_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_q <= RESET_TIME;
    else         time_q <= time_n;
  end

  assign time_o = time_q;

  a_r7_sec_moves_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((time_q[F_SEC] != $past(time_q[F_SEC])) && !$past(wr_i)) |-> $past(step_i));
  a_r4_mode_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(step_i) && !$past(wr_i)) |-> (time_q[F_HOUR][6] == $past(time_q[F_HOUR][6])));
endmodule

// File: rtl/bcd_rtc_alarm.sv
module bcd_rtc_alarm
  import bcd_rtc_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic                         acc_i,
  input  logic [1:0]                   idx_i,
  input  logic [7:0]                   wdata_i,
  input  logic [NUM_FIELDS-1:0][6:0]   time_i,
  input  logic                         chk_i,
  input  logic                         sts_wr_i,
  input  logic                         sts_keep_i,
  output logic [NUM_FIELDS-1:0][7:0]   alm_o,
  output logic                         flag_o
);
  logic [NUM_FIELDS-1:0][7:0] alm_q;
  logic [NUM_FIELDS-1:0]      fld_ok;
  logic                       hit, flag_q;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    assign fld_ok[f] = alm_q[f][7] | (alm_q[f][6:0] == time_i[f]);
  end

  assign hit = chk_i & (&fld_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   alm_q <= '0;
    else if (wr_i) alm_q[idx_i] <= wdata_i;
  end

  // a new match wins over a same-cycle clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                flag_q <= 1'b0;
    else if (hit)                               flag_q <= 1'b1;
    else if (acc_i || (sts_wr_i && !sts_keep_i)) flag_q <= 1'b0;
  end

  assign alm_o  = alm_q;
  assign flag_o = flag_q;

  a_r9_flag_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(chk_i));
  a_r11_access_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(acc_i && !hit) |-> !flag_q);
  a_r12_status_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sts_wr_i && !sts_keep_i && !hit) |-> !flag_q);
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned DIV    = 32768,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_main_no,
  output logic              irq_aux_no
);
  logic [NUM_TIME-1:0][7:0]                  time_v;
  logic [NUM_FIELDS-1:0][6:0]                cmp_time;
  logic [NUM_ALM-1:0][NUM_FIELDS-1:0][7:0]   alm_v;
  logic [NUM_ALM-1:0]                        alm_sel, flags;
  logic [NUM_ALM-1:0][1:0]                   alm_idx;
  logic [7:0] ctrl_q;
  logic time_sel, time_wr, step, stepped_q, ctrl_wr, stat_wr;
  logic main_act, aux_act;

  assign time_sel = addr_i < ADDR_W'(NUM_TIME);
  assign time_wr  = wr_en_i & time_sel;
  assign ctrl_wr  = wr_en_i & (addr_i == ADDR_W'(CTRL_ADDR));
  assign stat_wr  = wr_en_i & (addr_i == ADDR_W'(STAT_ADDR));

  bcd_rtc_prescaler #(.DIV(DIV)) u_presc (
    .clk_i, .rst_ni, .tick_i,
    .run_i(~ctrl_q[7]), .restart_i(time_wr), .step_o(step)
  );

  bcd_rtc_timekeeper u_time (
    .clk_i, .rst_ni, .wr_i(time_wr), .idx_i(addr_i[2:0]),
    .wdata_i, .step_i(step), .time_o(time_v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stepped_q <= 1'b0;
    else         stepped_q <= step;
  end

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cmp
    assign cmp_time[f] = time_v[f][6:0];
  end

  for (genvar k = 0; k < NUM_ALM; k++) begin : g_alm
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(ALM_BASE + NUM_FIELDS * k);
    logic [ADDR_W-1:0] off;
    assign off        = addr_i - BASE;
    assign alm_sel[k] = (addr_i >= BASE) && (addr_i < BASE + ADDR_W'(NUM_FIELDS));
    assign alm_idx[k] = off[1:0];

    bcd_rtc_alarm u_alm (
      .clk_i, .rst_ni,
      .wr_i(wr_en_i & alm_sel[k]),
      .acc_i((wr_en_i | rd_en_i) & alm_sel[k]),
      .idx_i(alm_idx[k]), .wdata_i, .time_i(cmp_time),
      .chk_i(stepped_q), .sts_wr_i(stat_wr), .sts_keep_i(wdata_i[k]),
      .alm_o(alm_v[k]), .flag_o(flags[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= 8'h00;
    else if (ctrl_wr) ctrl_q <= wdata_i & CTRL_MASK;
  end

  always_comb begin
    rdata_o = 8'h00;
    if (time_sel) rdata_o = time_v[addr_i[2:0]];
    for (int k = 0; k < NUM_ALM; k++)
      if (alm_sel[k]) rdata_o = alm_v[k][alm_idx[k]];
    if (addr_i == ADDR_W'(CTRL_ADDR)) rdata_o = ctrl_q;
    if (addr_i == ADDR_W'(STAT_ADDR)) rdata_o = 8'(flags);
  end

  assign main_act    = (flags[0] & ctrl_q[0]) | (flags[1] & ctrl_q[1] & ~ctrl_q[2]);
  assign aux_act     = flags[1] & ctrl_q[1] & ctrl_q[2];
  assign irq_main_no = ~main_act;
  assign irq_aux_no  = ~aux_act;

  a_r10_main_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_main_no |-> (|flags));
  a_r10_aux_needs_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_aux_no |-> (ctrl_q[2] && flags[1]));
  a_r8_halt_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[7] && !time_wr) |=> $stable(time_v));
endmodule

// File: tb/bcd_rtc_core_tb.sv
`timescale 1ns/1ps
module bcd_rtc_core_tb_top;
  localparam int DIV = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq_m_n, irq_a_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] cur [7];
  logic [7:0] v;

  always #2.5 clk = ~clk;

  bcd_rtc_core #(.DIV(DIV), .ADDR_W(5)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_main_no(irq_m_n), .irq_aux_no(irq_a_n)
  );

  function automatic logic [7:0] b2b(int x);
    return 8'(((x / 10) << 4) | (x % 10));
  endfunction
  function automatic int dim(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] henc(bit m12, int h);
    int hh;
    if (!m12) return b2b(h);
    hh = (h % 12 == 0) ? 12 : h % 12;
    return 8'h40 | (h >= 12 ? 8'h20 : 8'h00) | b2b(hh);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = '0;
  endtask
  task automatic peek(logic [4:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata; addr = '0;
  endtask
  task automatic rd_clr(logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1; d = rdata;
    @(negedge clk); rd_en = 1'b0; addr = '0;
  endtask
  task automatic ticks(int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask
  task automatic fetch();
    for (int i = 0; i < 7; i++) peek(5'(i), cur[i]);
  endtask
  task automatic set_time(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] wd,
                          logic [7:0] md, logic [7:0] mo, logic [7:0] y);
    wr(5'h00, s); wr(5'h01, m); wr(5'h02, h); wr(5'h03, wd);
    wr(5'h04, md); wr(5'h05, mo); wr(5'h06, y);
  endtask
  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 17; a++) begin
      logic [7:0] e;
      e = (a == 3 || a == 4 || a == 5) ? 8'h01 : 8'h00;
      peek(5'(a), v); chk($sformatf("R1 reg %0d", a), v, e);
    end
    chk("R1 irq_main", {7'b0, irq_m_n}, 8'h01);
    chk("R1 irq_aux", {7'b0, irq_a_n}, 8'h01);

    // R2 stored widths and unmapped space
    wr(5'h03, 8'hff); peek(5'h03, v); chk("R2 wday mask", v, 8'h07);
    wr(5'h04, 8'hff); peek(5'h04, v); chk("R2 mday mask", v, 8'h3f);
    wr(5'h05, 8'hff); peek(5'h05, v); chk("R2 mon mask", v, 8'h1f);
    wr(5'h0c, 8'hff); peek(5'h0c, v); chk("R2 alarm byte", v, 8'hff);
    wr(5'h0c, 8'h00);
    wr(5'h0f, 8'hff); peek(5'h0f, v); chk("R2 ctrl mask", v, 8'h87);
    wr(5'h0f, 8'h00);
    wr(5'h1f, 8'h5a); peek(5'h1f, v); chk("R2 unmapped", v, 8'h00);

    // R3/R4/R6 hour sweep in both formats
    for (int md = 0; md < 2; md++) begin
      for (int h = 0; h < 24; h++) begin
        int nh;
        bit wrap;
        nh = (h + 1) % 24; wrap = (h == 23);
        set_time(8'h59, 8'h59, henc(bit'(md), h), 8'h03, 8'h15, 8'h06, 8'h24);
        ticks(DIV); fetch();
        chk($sformatf("R3 sec m%0d h%0d", md, h), cur[0], 8'h00);
        chk($sformatf("R3 min m%0d h%0d", md, h), cur[1], 8'h00);
        chk($sformatf("%s hour m%0d h%0d", md ? "R4" : "R3", md, h), cur[2], henc(bit'(md), nh));
        chk($sformatf("R6 wday m%0d h%0d", md, h), cur[3], wrap ? 8'h04 : 8'h03);
        chk($sformatf("R4 mday m%0d h%0d", md, h), cur[4], wrap ? 8'h16 : 8'h15);
      end
    end

    // R5/R6 month ends across common, leap and last years
    for (int yi = 0; yi < 4; yi++) begin
      int y;
      y = (yi == 0) ? 23 : (yi == 1) ? 24 : (yi == 2) ? 0 : 99;
      for (int m = 1; m <= 12; m++) begin
        int d, nm, ny;
        d = dim(m, y);
        nm = (m == 12) ? 1 : m + 1;
        ny = (m == 12) ? (y + 1) % 100 : y;
        set_time(8'h59, 8'h59, 8'h23, 8'h06, b2b(d - 1), b2b(m), b2b(y));
        ticks(DIV); fetch();
        chk($sformatf("R5 early y%0d m%0d", y, m), cur[4], b2b(d));
        chk($sformatf("R5 nowrap mon y%0d m%0d", y, m), cur[5], b2b(m));
        chk($sformatf("R6 wday to 7 y%0d m%0d", y, m), cur[3], 8'h07);
        set_time(8'h59, 8'h59, 8'h23, 8'h07, b2b(d), b2b(m), b2b(y));
        ticks(DIV); fetch();
        chk($sformatf("R5 day y%0d m%0d", y, m), cur[4], 8'h01);
        chk($sformatf("R5 mon y%0d m%0d", y, m), cur[5], b2b(nm));
        chk($sformatf("R5 year y%0d m%0d", y, m), cur[6], b2b(ny));
        chk($sformatf("R6 wday wrap y%0d m%0d", y, m), cur[3], 8'h01);
      end
    end

    // R7 prescaler and restart on write
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    ticks(DIV - 1); peek(5'h00, v); chk("R7 before full second", v, 8'h10);
    wr(5'h00, 8'h20);
    ticks(DIV - 1); peek(5'h00, v); chk("R7 restart after write", v, 8'h20);
    ticks(1); peek(5'h00, v); chk("R7 step after DIV ticks", v, 8'h21);
    ticks(4 * DIV); peek(5'h00, v); chk("R7 steady rate", v, 8'h25);

    // R8 halt
    wr(5'h00, 8'h30);
    wr(5'h0f, 8'h80);
    ticks(5 * DIV); peek(5'h00, v); chk("R8 halted", v, 8'h30);
    wr(5'h0f, 8'h00);
    ticks(DIV); peek(5'h00, v); chk("R8 resumes", v, 8'h31);

    // R9/R10 exact match on alarm 0
    wr(5'h07, 8'h31); wr(5'h08, 8'h20); wr(5'h09, 8'h10); wr(5'h0a, 8'h02);
    wr(5'h0f, 8'h01);
    set_time(8'h30, 8'h20, 8'h10, 8'h02, 8'h01, 8'h01, 8'h00);
    chk("R10 idle main", {7'b0, irq_m_n}, 8'h01);
    ticks(DIV); peek(5'h10, v); chk("R9 alarm0 flag", v, 8'h01);
    chk("R10 main low", {7'b0, irq_m_n}, 8'h00);
    chk("R10 aux high", {7'b0, irq_a_n}, 8'h01);
    wr(5'h0f, 8'h00);
    chk("R10 disabled main", {7'b0, irq_m_n}, 8'h01);
    peek(5'h10, v); chk("R10 flag kept", v, 8'h01);

    // R11 read clears
    rd_clr(5'h09, v); chk("R11 read data", v, 8'h10);
    peek(5'h10, v); chk("R11 read clears", v, 8'h00);

    // R9 mismatch
    wr(5'h07, 8'h45);
    set_time(8'h30, 8'h20, 8'h10, 8'h02, 8'h01, 8'h01, 8'h00);
    ticks(DIV); peek(5'h10, v); chk("R9 no match", v, 8'h00);

    // R9 masking
    wr(5'h07, 8'h80); wr(5'h0a, 8'h80);
    set_time(8'h30, 8'h20, 8'h10, 8'h05, 8'h01, 8'h01, 8'h00);
    ticks(DIV); peek(5'h10, v); chk("R9 masked match", v, 8'h01);
    wr(5'h08, 8'h21); peek(5'h10, v); chk("R11 write clears", v, 8'h00);
    ticks(DIV); peek(5'h10, v); chk("R9 unmasked mismatch", v, 8'h00);

    // R10 routing with alarm 1 fully masked
    wr(5'h0a, 8'h00);
    wr(5'h0b, 8'h80); wr(5'h0c, 8'h80); wr(5'h0d, 8'h80); wr(5'h0e, 8'h80);
    wr(5'h0f, 8'h02);
    ticks(DIV); peek(5'h10, v); chk("R9 alarm1 flag", v, 8'h02);
    chk("R10 unrouted main", {7'b0, irq_m_n}, 8'h00);
    chk("R10 unrouted aux", {7'b0, irq_a_n}, 8'h01);
    wr(5'h0f, 8'h06);
    chk("R10 routed main", {7'b0, irq_m_n}, 8'h01);
    chk("R10 routed aux", {7'b0, irq_a_n}, 8'h00);

    // R11 other alarm untouched
    rd_clr(5'h07, v); peek(5'h10, v); chk("R11 other flag kept", v, 8'h02);

    // R12 status writes
    wr(5'h10, 8'h02); peek(5'h10, v); chk("R12 one keeps", v, 8'h02);
    wr(5'h10, 8'h00); peek(5'h10, v); chk("R12 zero clears", v, 8'h00);
    chk("R12 aux released", {7'b0, irq_a_n}, 8'h01);
    ticks(DIV); peek(5'h10, v); chk("R12 re-arm", v, 8'h02);
    wr(5'h10, 8'h01); peek(5'h10, v); chk("R12 bit clear", v, 8'h00);

    done = 1;
    summary();
    $finish;
  end
endmodule